// File: doc/BRIEF.md
# Pipeline Stall Controller with Non-Stallable Stages

This block produces the per-stage control for a linear pipeline whose length is a parameter and that is held by one global stall input. A parameter mask selects the stages that cannot be stopped once started, such as stages wrapped around a fixed-latency resource. For every stage the block reports two things: whether the stage's output registers hold a real item or a bubble, and the clock-enable that lets those registers load. A go/valid input enters at the head, and a valid output leaves at the tail. That tail valid is meant to drive the write-valid of a consumer-side buffer.

Each stage is one of three kinds. A stage that comes before the first marked stage is a holding stage and freezes during a stall. A marked stage keeps loading on every cycle. Every unmarked stage after the first marked one is a draining stage. A draining stage moves while stall is low. During a stall it moves only when its predecessor hands it a real item, so items already launched by the marked stages are carried out of the pipeline instead of being overwritten. When stall rises on a full pipeline, the tail therefore emits one item per marked stage and then goes quiet. The consumer's buffer must hold at least that many entries.

A small payload travels with each item, and every stage adds one to it, so results can be checked at the tail.

Top module: `nsp_pipeline`

## Requirements
- R1: After a synchronous active-high reset, every bit of `stage_occ` is 0 and `out_valid` is 0.
- R2: While `stall` is low, every bit of `stage_en` is 1 and each item advances one stage per clock.
- R3: Bit i of `FIXED_MASK` set to 1 marks stage i as non-stallable. Unmarked stages with a lower index than the lowest marked stage are holding stages, and all other unmarked stages are draining stages. With the default mask 6'b000110 and an empty pipeline under stall, `stage_en` equals 6'b000110.
- R4: While `stall` is high, the enable of a holding stage is 0 and its occupied flag keeps its value.
- R5: The enable of a non-stallable stage is 1 in every cycle, whatever the value of `stall`.
- R6: While `stall` is high, a draining stage's enable is 1 exactly when its predecessor is occupied and its predecessor's enable is 1.
- R7: No accepted item is dropped or duplicated, items leave in arrival order, and `out_data` equals the accepted `in_data` plus NUM_STAGES, modulo 2^DATA_W.
- R8: When a stage's enable is 1, its occupied flag loads the predecessor's flag ANDed with the predecessor's enable. Stage 0 loads `in_valid` instead. A stage that loads while its predecessor is frozen therefore receives a bubble.
- R9: When `stall` rises on a completely full pipeline and stays high, the tail emits exactly as many valid outputs as there are marked stages (2 for the default), and then none until `stall` falls.
- R10: `in_valid` is accepted only in a cycle where `stage_en[0]` is 1. An offer made while it is 0 is ignored.
- R11: `out_valid` is 1 exactly when the last stage is occupied and its enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Global stall request |
| in_valid | input | 1 | Item offered at the head |
| in_data | input | DATA_W | Payload of the offered item |
| stage_occ | output | NUM_STAGES | Per-stage occupied flag |
| stage_en | output | NUM_STAGES | Per-stage output-register clock-enable |
| out_valid | output | 1 | Item leaving the tail (buffer write valid) |
| out_data | output | DATA_W | Payload of the leaving item |

## Verification
Two events can land on the same clock edge. In the first, stall rises while a marked stage is handing a real item to a draining stage. In the second, the head is offered a new item while its holding stage is frozen. The bench fills the pipeline completely, raises stall while it keeps offering input, and counts the tail outputs against the number of marked stages. It then runs long random stretches of bursty stall and sparse input. Every cycle it compares every enable, every occupied flag and the tail against a slot-array reference model, and it uses a scoreboard queue to catch any loss, repeat or reordering of items.

// File: rtl/nsp_pkg.sv
package nsp_pkg;

   localparam int MAX_STAGES = 64;

   typedef enum logic [1:0] {
      KIND_HOLD   = 2'd0,
      KIND_FIXED  = 2'd1,
      KIND_RUNOFF = 2'd2
   } stage_kind_e;

   // Class of stage idx given the non-stallable mask.
   function automatic stage_kind_e kind_of(input logic [MAX_STAGES-1:0] mask, input int idx);
      logic seen;
      seen = 1'b0;
      for (int j = 0; j < MAX_STAGES; j++) begin
         if (j < idx && mask[j]) seen = 1'b1;
      end
      if (mask[idx]) return KIND_FIXED;
      if (seen)      return KIND_RUNOFF;
      return KIND_HOLD;
   endfunction

   // Number of marked stages among the first n.
   function automatic int count_fixed(input logic [MAX_STAGES-1:0] mask, input int n);
      int c;
      c = 0;
      for (int j = 0; j < MAX_STAGES; j++) begin
         if (j < n && mask[j]) c++;
      end
      return c;
   endfunction

endpackage

// File: rtl/nsp_stage_enable.sv
module nsp_stage_enable
   import nsp_pkg::*;
#(
   parameter stage_kind_e KIND = KIND_HOLD
) (
   input  logic stall,
   input  logic up_occ,
   input  logic up_adv,
   output logic adv
);

   localparam logic FREE  = (KIND == KIND_FIXED);
   localparam logic CHAIN = (KIND == KIND_RUNOFF);

   // Free-running stages always load; draining stages also load
   // whenever the predecessor is releasing a real item.
   always_comb begin
      adv = FREE | ~stall | (CHAIN & up_occ & up_adv);
   end

endmodule

// File: rtl/nsp_stage_slot.sv
module nsp_stage_slot #(
   parameter int              DATA_W = 16,
   parameter logic [DATA_W-1:0] STEP = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic              arr_valid,
   input  logic [DATA_W-1:0] arr_data,
   output logic              occ,
   output logic [DATA_W-1:0] data
);

   always_ff @(posedge clk) begin
      if (rst) begin
         occ  <= 1'b0;
         data <= '0;
      end else if (adv) begin
         occ  <= arr_valid;
         data <= arr_data + STEP;
      end
   end

endmodule

// File: rtl/nsp_pipeline.sv
module nsp_pipeline
   import nsp_pkg::*;
#(
   parameter int                    NUM_STAGES = 6,
   parameter int                    DATA_W     = 16,
   parameter logic [NUM_STAGES-1:0] FIXED_MASK = 6'b000110
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  stall,
   input  logic                  in_valid,
   input  logic [DATA_W-1:0]     in_data,
   output logic [NUM_STAGES-1:0] stage_occ,
   output logic [NUM_STAGES-1:0] stage_en,
   output logic                  out_valid,
   output logic [DATA_W-1:0]     out_data
);

   localparam logic [MAX_STAGES-1:0] MASK_WIDE = MAX_STAGES'(FIXED_MASK);
   localparam logic [DATA_W-1:0]     STEP      = DATA_W'(1);
   localparam int                    LAST      = NUM_STAGES - 1;

   generate
      if (NUM_STAGES < 2 || NUM_STAGES > MAX_STAGES) begin : g_bad_len
         $error("nsp_pipeline: NUM_STAGES out of range");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("nsp_pipeline: DATA_W must be positive");
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
         logic              adv_w;
         logic              occ_w;
         logic [DATA_W-1:0] data_w;
         logic              arr_valid_w;
         logic [DATA_W-1:0] arr_data_w;
         logic              up_occ_w;
         logic              up_adv_w;

         if (i == 0) begin : g_head
            assign arr_valid_w = in_valid;
            assign arr_data_w  = in_data;
            assign up_occ_w    = 1'b0;
            assign up_adv_w    = 1'b0;
         end else begin : g_link
            // An item is released only when its holder loads this cycle.
            assign arr_valid_w = g_stage[i-1].occ_w & g_stage[i-1].adv_w;
            assign arr_data_w  = g_stage[i-1].data_w;
            assign up_occ_w    = g_stage[i-1].occ_w;
            assign up_adv_w    = g_stage[i-1].adv_w;
         end

         nsp_stage_enable #(
            .KIND (kind_of(MASK_WIDE, i))
         ) u_en (
            .stall  (stall),
            .up_occ (up_occ_w),
            .up_adv (up_adv_w),
            .adv    (adv_w)
         );

         nsp_stage_slot #(
            .DATA_W (DATA_W),
            .STEP   (STEP)
         ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .adv       (adv_w),
            .arr_valid (arr_valid_w),
            .arr_data  (arr_data_w),
            .occ       (occ_w),
            .data      (data_w)
         );

         assign stage_en[i]  = adv_w;
         assign stage_occ[i] = occ_w;
      end
   endgenerate

   assign out_valid = g_stage[LAST].occ_w & g_stage[LAST].adv_w;
   assign out_data  = g_stage[LAST].data_w;

endmodule

// File: rtl/nsp_pipeline_chk.sv
module nsp_pipeline_chk
   import nsp_pkg::*;
#(
   parameter int                    NUM_STAGES = 6,
   parameter logic [NUM_STAGES-1:0] FIXED_MASK = 6'b000110
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  stall,
   input logic [NUM_STAGES-1:0] stage_occ,
   input logic [NUM_STAGES-1:0] stage_en,
   input logic                  out_valid
);

   localparam logic [MAX_STAGES-1:0] MASK_WIDE = MAX_STAGES'(FIXED_MASK);
   localparam int NUM_FIXED = count_fixed(MASK_WIDE, NUM_STAGES);

   int drain_cnt;

   always_ff @(posedge clk) begin
      if (rst || !stall) drain_cnt <= 0;
      else if (out_valid) drain_cnt <= drain_cnt + 1;
   end

   a_r1_reset_clear : assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (stage_occ == '0 && !out_valid));

   a_r2_free_flow : assert property (@(posedge clk) disable iff (rst)
      !stall |-> (&stage_en));

   generate
      for (genvar i = 0; i < NUM_STAGES; i++) begin : g_chk
         localparam stage_kind_e K = kind_of(MASK_WIDE, i);
         if (K == KIND_HOLD) begin : g_hold
            a_r4_hold_frozen : assert property (@(posedge clk) disable iff (rst)
               stall |-> !stage_en[i]);
            a_r4_hold_keeps : assert property (@(posedge clk) disable iff (rst)
               stall |=> $stable(stage_occ[i]));
         end
         if (K == KIND_FIXED) begin : g_fixed
            a_r5_fixed_runs : assert property (@(posedge clk) disable iff (rst)
               stage_en[i]);
         end
         if (K == KIND_RUNOFF) begin : g_runoff
            a_r6_runoff_idle : assert property (@(posedge clk) disable iff (rst)
               (stall && !stage_occ[i-1]) |-> !stage_en[i]);
         end
         if (i > 0) begin : g_link
            a_r7_no_drop : assert property (@(posedge clk) disable iff (rst)
               (stage_occ[i-1] && stage_en[i-1]) |-> stage_en[i]);
            if (kind_of(MASK_WIDE, i-1) == KIND_HOLD) begin : g_bub
               a_r8_bubble_in : assert property (@(posedge clk) disable iff (rst)
                  (stall && stage_en[i]) |=> !stage_occ[i]);
            end
         end
      end
      if (kind_of(MASK_WIDE, 0) == KIND_HOLD) begin : g_drain
         a_r9_drain_bound : assert property (@(posedge clk) disable iff (rst)
            (stall && out_valid) |-> (drain_cnt < NUM_FIXED));
      end
   endgenerate

endmodule

bind nsp_pipeline nsp_pipeline_chk #(
   .NUM_STAGES (NUM_STAGES),
   .FIXED_MASK (FIXED_MASK)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .stall     (stall),
   .stage_occ (stage_occ),
   .stage_en  (stage_en),
   .out_valid (out_valid)
);

// File: tb/nsp_pipeline_test.sv
`timescale 1ns/1ps
module nsp_pipeline_test;

   localparam int N = 6;
   localparam int W = 16;
   localparam logic [N-1:0] MASK = 6'b000110;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         stall = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic [N-1:0] stage_occ;
   logic [N-1:0] stage_en;
   logic         out_valid;
   logic [W-1:0] out_data;

   int checks = 0;
   int errors = 0;
   int slot [N];
   int kind [N];      // 0 holding, 1 marked, 2 draining
   int sb [$];
   int accepted = 0;
   int emitted = 0;

   always #2.5 clk = ~clk;

   nsp_pipeline #(.NUM_STAGES(N), .DATA_W(W), .FIXED_MASK(MASK)) uut (
      .clk, .rst, .stall, .in_valid, .in_data,
      .stage_occ, .stage_en, .out_valid, .out_data
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic string en_tag(input int k);
      if (k == 0) return "R4";
      if (k == 1) return "R5";
      return "R6";
   endfunction

   // Drive one cycle, compare against the model, then advance the model.
   task automatic cycle(input bit s, input bit v, input int d);
      bit en_exp [N];
      int old [N];
      bit ov;
      @(negedge clk);
      stall = s; in_valid = v; in_data = W'(d);
      #1;
      for (int i = 0; i < N; i++) begin
         if (kind[i] == 1) en_exp[i] = 1'b1;
         else if (kind[i] == 0) en_exp[i] = !s;
         else en_exp[i] = !s || (en_exp[i-1] && slot[i-1] >= 0);
      end
      for (int i = 0; i < N; i++) begin
         check(stage_en[i] == en_exp[i], s ? en_tag(kind[i]) : "R2",
               $sformatf("stage_en[%0d]", i), int'(stage_en[i]), int'(en_exp[i]));
         check(stage_occ[i] == (slot[i] >= 0), "R8",
               $sformatf("stage_occ[%0d]", i), int'(stage_occ[i]), int'(slot[i] >= 0));
      end
      ov = (slot[N-1] >= 0) && en_exp[N-1];
      check(out_valid == ov, "R11", "out_valid", int'(out_valid), int'(ov));
      if (ov && out_valid)
         check(out_data == W'(slot[N-1] + N), "R7", "out_data",
               int'(out_data), int'(W'(slot[N-1] + N)));
      if (v && en_exp[0]) begin
         sb.push_back(d & 16'hFFFF);
         accepted++;
      end
      if (out_valid) begin
         emitted++;
         if (sb.size() == 0) check(1'b0, "R7", "output with empty scoreboard", 1, 0);
         else begin
            int e;
            e = sb.pop_front();
            check(out_data == W'(e + N), "R7", "scoreboard order", int'(out_data), int'(W'(e + N)));
         end
      end
      old = slot;
      for (int i = 0; i < N; i++) begin
         if (en_exp[i]) begin
            if (i == 0) slot[i] = v ? (d & 16'hFFFF) : -1;
            else slot[i] = en_exp[i-1] ? old[i-1] : -1;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int drained;
      int next_val;
      begin
         bit seen;
         seen = 1'b0;
         for (int i = 0; i < N; i++) begin
            if (MASK[i]) begin kind[i] = 1; seen = 1'b1; end
            else kind[i] = seen ? 2 : 0;
         end
      end
      for (int i = 0; i < N; i++) slot[i] = -1;
      next_val = 100;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      check(stage_occ == '0, "R1", "stage_occ after reset", int'(stage_occ), 0);
      check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

      // R3: class pattern on an empty, stalled pipeline
      cycle(1'b1, 1'b0, 0);
      check(stage_en == 6'b000110, "R3", "stage_en pattern", int'(stage_en), 6);

      // R2: free flow, fill completely
      for (int k = 0; k < 10; k++) begin
         cycle(1'b0, 1'b1, next_val);
         next_val++;
         check(&stage_en, "R2", "all enables high", int'(stage_en), 63);
      end
      check(stage_occ == '1, "R2", "pipeline full", int'(stage_occ), 63);

      // R9 / R10: stall on full pipeline while input is still offered
      drained = 0;
      for (int k = 0; k < 8; k++) begin
         cycle(1'b1, 1'b1, 9000 + k);
         if (out_valid) drained++;
      end
      check(drained == 2, "R9", "trailing outputs after stall", drained, 2);
      check(accepted == 10, "R10", "offers during stall ignored", accepted, 10);

      // Random bursty stall with sparse input
      for (int k = 0; k < 3000; k++) begin
         bit s;
         s = ($urandom_range(0, 9) < ((k / 200) % 2 == 0 ? 3 : 7));
         cycle(s, $urandom_range(0, 3) != 0, next_val);
         next_val++;
      end

      // Drain everything
      for (int k = 0; k < 20; k++) cycle(1'b0, 1'b0, 0);
      check(sb.size() == 0, "R7", "items left undelivered", sb.size(), 0);
      check(emitted == accepted, "R10", "emitted equals accepted", emitted, accepted);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule